// File: doc/BRIEF.md
# One-of-Four Return-to-Zero Data Link

This block carries a data word between two ends of a chip over a link that needs no shared clock to tell when data has arrived. The sending side takes a word on a ready/valid input and splits it into 2-bit groups. Each group goes out on its own set of four wires as a one-hot code. The receiving side watches only the wire codes. Once every group holds a legal code, it captures the word, presents it for one cycle on its output and raises a single acknowledge wire.

Each transfer is closed with a return-to-zero spacer. After the acknowledge rises, the sender drops every wire. The receiver lowers the acknowledge once it sees all wires low. The sender then accepts the next word.

The logic is modelled with synchronous registers on one clock, and the link is point-to-point. A force input can be ORed onto the wires to model a disturbed link. A group that shows more than one high wire is never taken as data, and it sets a sticky protocol-error flag.

Top module: `onehot4_link`

## Requirements
- R1: While reset is held and at release, every link wire, `link_ack`, `out_valid`, `out_data` and `proto_err` are low, and `in_ready` is high.
- R2: An accepted word drives, for each group g, exactly wire 4g+v of `link_wires`, where v is data bits [2g+1:2g]. Value 0 selects the lowest wire of the group and value 3 the highest.
- R3: The cycle after every group shows exactly one high wire while the acknowledge is low, `link_ack` rises. In that same cycle `out_valid` pulses for one cycle and `out_data` carries the decoded word.
- R4: While any group is all-zero or has more than one high wire, the receiver neither raises `link_ack` nor asserts `out_valid`.
- R5: The cycle after the sender sees `link_ack` high, it drives all of its wires low (the spacer).
- R6: `link_ack` falls the cycle after every wire of every group is low. While any wire stays high, it stays high.
- R7: `in_ready` is high only when the sender is idle and `link_ack` is low. `in_valid` and `in_data` while `in_ready` is low have no effect on the wires or on the word delivered.
- R8: A group seen with two or more high wires sets `proto_err`. `proto_err` stays set until reset.
- R9: `wire_force` is ORed onto the transmitted wires before the receiver and the `link_wires` output. With the parameter default, W is 16 and there are 8 groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sender word valid |
| in_ready | output | 1 | Sender can accept a word |
| in_data | input | W | Word to send |
| wire_force | input | 2*W | Disturbance ORed onto the link wires |
| link_wires | output | 2*W | One-hot groups of four wires as seen on the link |
| link_ack | output | 1 | Receiver acknowledge wire |
| out_valid | output | 1 | One-cycle pulse with a received word |
| out_data | output | W | Received word |
| proto_err | output | 1 | Sticky multi-hot error flag |

## Verification
On every cycle, the assertions check these rules:
- the acknowledge only rises after a complete one-hot code, and only falls after an all-low spacer;
- the output pulse lasts a single cycle;
- the sender is only ready while the acknowledge is low;
- the sender returns to zero after acknowledge;
- an undisturbed group never shows two wires;
- the error flag is sticky.

Only the bench scenarios can show the rest:
- the exact wire chosen for each value and the decoded word;
- that words offered while busy are dropped;
- that a multi-hot group stalls completion until the disturbance clears;
- that a held wire delays the falling acknowledge;
- that only reset clears the error.

// File: rtl/onehot4_link.sv
module onehot4_link #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  input  logic [2*W-1:0] wire_force,
  output logic [2*W-1:0] link_wires,
  output logic           link_ack,
  output logic           out_valid,
  output logic [W-1:0]   out_data,
  output logic           proto_err
);
  localparam int G  = W / 2;
  localparam int NW = 4 * G;

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_RTZ} tx_st_t;

  tx_st_t          tx_st;
  logic [NW-1:0]   tx_drive;
  logic [NW-1:0]   enc;
  logic [W-1:0]    dec;
  logic [G-1:0]    grp_one;
  logic [G-1:0]    grp_multi;
  logic            all_one;
  logic            all_zero;

  if ((W % 2) != 0 || W < 2) begin : g_bad_width
    $error("onehot4_link: W must be even and at least 2");
  end

  for (genvar g = 0; g < G; g++) begin : g_grp
    logic [3:0] q;
    assign q = link_wires[4*g +: 4];
    assign enc[4*g +: 4] = 4'b0001 << in_data[2*g +: 2];
    assign grp_one[g] = (q == 4'b0001) || (q == 4'b0010) ||
                        (q == 4'b0100) || (q == 4'b1000);
    assign grp_multi[g] = (q != 4'b0000) && !grp_one[g];
    assign dec[2*g +: 2] = {q[3] | q[2], q[3] | q[1]};
  end

  assign link_wires = tx_drive | wire_force;
  assign all_one    = &grp_one;
  assign all_zero   = (link_wires == '0);
  assign in_ready   = (tx_st == TX_IDLE) && !link_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st    <= TX_IDLE;
      tx_drive <= '0;
    end else begin
      case (tx_st)
        TX_IDLE: if (in_valid && in_ready) begin
          tx_drive <= enc;
          tx_st    <= TX_DATA;
        end
        TX_DATA: if (link_ack) begin
          tx_drive <= '0;
          tx_st    <= TX_RTZ;
        end
        TX_RTZ: if (!link_ack) tx_st <= TX_IDLE;
        default: tx_st <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_ack  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      proto_err <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (!link_ack && all_one) begin
        link_ack  <= 1'b1;
        out_valid <= 1'b1;
        out_data  <= dec;
      end else if (link_ack && all_zero) begin
        link_ack <= 1'b0;
      end
      if (|grp_multi) proto_err <= 1'b1;
    end
  end
endmodule

module onehot4_link_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic [2*W-1:0] wire_force,
  input logic [2*W-1:0] link_wires,
  input logic           link_ack,
  input logic           out_valid,
  input logic           proto_err
);
  localparam int G = W / 2;
  logic [G-1:0] c_one;

  for (genvar g = 0; g < G; g++) begin : g_c
    assign c_one[g] = ($countones(link_wires[4*g +: 4]) == 1);
    p_undisturbed_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wire_force == '0) |-> ($countones(link_wires[4*g +: 4]) <= 1));
  end

  p_ack_rise_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ack) |-> $past(&c_one));
  p_out_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_rtz_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ack && in_ready == 1'b0 && $rose(link_ack)) |=> ((link_wires & ~wire_force) == '0));
  p_ack_fall_spacer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ack) |-> $past(link_wires == '0));
  p_ready_ack_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !link_ack);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind onehot4_link onehot4_link_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wire_force(wire_force),
  .link_wires(link_wires), .link_ack(link_ack), .out_valid(out_valid),
  .proto_err(proto_err)
);

// File: tb/sim_onehot4_link.sv
module sim_onehot4_link;
  localparam int W  = 16;
  localparam int G  = W / 2;
  localparam int NW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  in_data;
  logic [NW-1:0] wire_force;
  logic          in_ready, link_ack, out_valid, proto_err;
  logic [NW-1:0] link_wires;
  logic [W-1:0]  out_data;

  onehot4_link #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wire_force(wire_force), .link_wires(link_wires),
    .link_ack(link_ack), .out_valid(out_valid), .out_data(out_data),
    .proto_err(proto_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int            m_phase;
  logic [NW-1:0] m_tx;
  logic          m_ack, m_ov, m_err;
  logic [W-1:0]  m_od;
  logic [W-1:0]  sent_q[$];

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2/R5/R9", "link_wires", 64'(link_wires), 64'(m_tx | wire_force));
    check("R3/R6", "link_ack", 64'(link_ack), 64'(m_ack));
    check("R3/R4", "out_valid", 64'(out_valid), 64'(m_ov));
    check("R3", "out_data", 64'(out_data), 64'(m_od));
    check("R7", "in_ready", 64'(in_ready), 64'(m_phase == 0 && !m_ack));
    check("R8", "proto_err", 64'(proto_err), 64'(m_err));
  endtask

  task automatic step(input logic v, input logic [W-1:0] d, input logic [NW-1:0] f);
    logic [NW-1:0] w;
    bit allone, anymulti;
    int cnt;
    int n_phase;
    logic [NW-1:0] n_tx;
    logic n_ack, n_ov, n_err;
    logic [W-1:0] n_od;
    in_valid = v; in_data = d; wire_force = f;
    w = m_tx | f;
    allone = 1; anymulti = 0;
    n_od = m_od;
    for (int g = 0; g < G; g++) begin
      cnt = 0;
      for (int b = 0; b < 4; b++) if (w[4*g+b]) begin
        cnt++;
        n_od[2*g +: 2] = 2'(b);
      end
      if (cnt != 1) allone = 0;
      if (cnt > 1) anymulti = 1;
    end
    n_phase = m_phase; n_tx = m_tx;
    if (m_phase == 0 && !m_ack && v) begin
      n_tx = '0;
      for (int g = 0; g < G; g++) n_tx[4*g + int'(d[2*g +: 2])] = 1'b1;
      n_phase = 1;
      sent_q.push_back(d);
    end else if (m_phase == 1 && m_ack) begin
      n_tx = '0; n_phase = 2;
    end else if (m_phase == 2 && !m_ack) begin
      n_phase = 0;
    end
    n_ack = m_ack; n_ov = 0; n_err = m_err | anymulti;
    if (!m_ack && allone) begin
      n_ack = 1; n_ov = 1;
    end else begin
      n_od = m_od;
      if (m_ack && w == '0) n_ack = 0;
    end
    @(posedge clk);
    @(negedge clk);
    m_phase = n_phase; m_tx = n_tx; m_ack = n_ack; m_ov = n_ov;
    m_od = n_od; m_err = n_err;
    compare_all();
    if (out_valid && m_ov && sent_q.size() > 0) begin
      logic [W-1:0] e;
      e = sent_q.pop_front();
      check("R3", "word delivered", 64'(out_data), 64'(e));
    end
  endtask

  task automatic send(input logic [W-1:0] d);
    while (!(m_phase == 0 && !m_ack)) step(1'b1, ~d, '0);
    step(1'b1, d, '0);
    for (int i = 0; i < 4; i++) step(1'b1, d ^ 16'h3C3C, '0);
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; in_data = '0; wire_force = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_phase = 0; m_tx = '0; m_ack = 0; m_ov = 0; m_od = '0; m_err = 0;
    sent_q.delete();
    compare_all();
    rst_n = 1;
    step(1'b0, '0, '0);
  endtask

  initial begin
    logic [W-1:0] lfsr;
    do_reset();
    // R1 reset state
    check("R1", "in_ready after reset", 64'(in_ready), 64'd1);
    check("R1", "wires after reset", 64'(link_wires), 64'd0);
    // R2 R3 R5 R6 R7: fixed patterns, garbage offered while busy
    send(16'h0000);
    send(16'hFFFF);
    send(16'h1B1B);
    send(16'hE4E4);
    send(16'h5A5A);
    // R2: value 3 in group 0 lands on wire 3, value 0 elsewhere on wire 0
    while (!(m_phase == 0 && !m_ack)) step(1'b0, '0, '0);
    step(1'b1, 16'h0003, '0);
    check("R2", "group encoding", 64'(link_wires), 64'h0000_0000_1111_1118);
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0);
    // R4 R8: multi-hot group stalls completion and sets error
    step(1'b1, 16'h0000, 32'h0000_0002);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, 32'h0000_0002);
      check("R4", "no ack while multi-hot", 64'(link_ack), 64'd0);
    end
    check("R8", "error set", 64'(proto_err), 64'd1);
    for (int i = 0; i < 6; i++) step(1'b0, '0, '0);
    check("R8", "error sticky", 64'(proto_err), 64'd1);
    // R6: held wire delays acknowledge fall
    step(1'b1, 16'h0001, '0);
    step(1'b0, '0, 32'h0000_0002);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, '0, 32'h0000_0002);
      check("R6", "ack held by stuck wire", 64'(link_ack), 64'd1);
    end
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0);
    check("R6", "ack low after spacer", 64'(link_ack), 64'd0);
    // R9: random words with the default width
    lfsr = 16'hACE1;
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr);
    end
    // R8 R1: only reset clears the error
    do_reset();
    check("R8", "error cleared by reset", 64'(proto_err), 64'd0);
    send(16'h9C63);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule